// File: doc/BRIEF.md
# RTC Event Status and Alarm Unit

This unit turns the progress of a real-time clock into interrupt events. It watches the packed time value from the clock's counter on every 1 Hz tick and raises events for three cases. The first is a change in the second, minute, hour or day field. The second is a match against a programmable alarm register. The third is a stopwatch down-counter that reaches zero. Each event sets a sticky bit in a status register. Software clears these bits by writing ones to them. A matching enable register, with the same bit positions, selects which events drive the single interrupt line.

The packed time format places seconds in bits 5:0, minutes in 11:6, hours in 16:12 and the day count in 31:17. The alarm register uses the same layout. Two alarm events come from that one register. The daily alarm compares only the seconds, minutes and hours. The day alarm also compares the day count.

All pins are plain control and status pins. There is no streamed data, so no valid/ready handshake applies. Software writes through a single write strobe with a 2-bit target select: 0 status clear, 1 enable, 2 alarm, 3 stopwatch load.

Top module: `rtc_evt_unit`

## Requirements
- R1: After reset, the status, enable, alarm and stopwatch registers read zero and the interrupt is low. Event bit positions: 0 stopwatch, 1 daily alarm, 2 second, 3 minute, 4 hour, 5 day rollover, 6 day alarm. Bits 15:7 always read zero.
- R2: On a tick, each of bits 2, 3, 4 and 5 is set when its field (seconds 5:0, minutes 11:6, hours 16:12, day 31:17) differs from the value seen on the previous tick. Before the first tick, that previous value is zero.
- R3: On a tick whose bits 16:0 equal the alarm register's bits 16:0, status bit 1 is set, whatever the day field holds.
- R4: On a tick whose full 32-bit time equals the alarm register, status bit 6 is set, together with bit 1.
- R5: Without a tick, no event bit is set, even if the time input changes.
- R6: A status write clears each bit 6:0 written as one and leaves the bits written as zero. Writing 0xFFFF clears every bit. An event raised in the same cycle as its clear leaves the bit set.
- R7: An enable write stores data bits 6:0. Enable bits 15:7 read zero.
- R8: The interrupt output is high exactly when status AND enable is nonzero.
- R9: On each tick, a nonzero stopwatch count decrements by one. The step from 1 to 0 sets status bit 0. A count of zero holds and raises nothing, and loading zero raises no event.
- R10: A stopwatch load (data bits 15:0) in the same cycle as a tick takes the loaded value, with no decrement and no event.
- R11: An alarm write stores the full 32-bit value and reads it back. A match in the write cycle uses the old alarm value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse: time_i holds the value just reached by the 1 Hz counter |
| time_i | input | 32 | Packed current time from the counter |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status clear, 1 enable, 2 alarm, 3 stopwatch |
| wr_data_i | input | 32 | Write data |
| status_o | output | 16 | Sticky event status |
| enable_o | output | 16 | Event enables |
| alarm_o | output | 32 | Alarm register |
| swatch_o | output | 16 | Stopwatch count |
| irq_o | output | 1 | Interrupt request |

## Verification
Random time values rarely match the alarm register. This makes the day-alarm case the hardest to reach, along with a daily match whose day field differs. To reach them, the stimulus builds most time values from the current alarm value: sometimes an exact copy, sometimes with only the day bits redrawn, sometimes with one seconds bit flipped. The stopwatch is also loaded with small counts. Its expiry then lands on ticks that coincide with writes and status clears, and directed steps force a load, a tick and a clear into the same cycle.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int TIME_W  = 32;
  localparam int SEC_LSB = 0;
  localparam int SEC_W   = 6;
  localparam int MIN_LSB = 6;
  localparam int MIN_W   = 6;
  localparam int HR_LSB  = 12;
  localparam int HR_W    = 5;
  localparam int DAY_LSB = 17;
  localparam int DAY_W   = 15;
  localparam int TOD_W   = DAY_LSB;   // width of the seconds/minutes/hours span
  localparam int NFIELD  = 4;

  localparam int EV_SWATCH = 0;
  localparam int EV_ALARM  = 1;
  localparam int EV_SEC    = 2;       // EV_SEC..EV_SEC+3 follow the field order
  localparam int EV_DAYALM = 6;
  localparam int EV_N      = 7;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_ALARM  = 2'd2,
    SEL_SWATCH = 2'd3
  } wsel_e;
endpackage

// File: rtl/rtc_evt_detect.sv
module rtc_evt_detect
  import rtc_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              alarm_we_i,
  input  logic [TIME_W-1:0] alarm_wdata_i,
  output logic [TIME_W-1:0] alarm_o,
  output logic [EV_N-1:0]   evt_o
);
  localparam int FLD_LSB [NFIELD] = '{SEC_LSB, MIN_LSB, HR_LSB, DAY_LSB};
  localparam int FLD_W   [NFIELD] = '{SEC_W, MIN_W, HR_W, DAY_W};

  logic [TIME_W-1:0] prev_q;
  logic [TIME_W-1:0] alarm_q;
  logic [NFIELD-1:0] fld_chg;
  logic              tod_hit, full_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      alarm_q <= '0;
    end else begin
      if (tick_i)     prev_q  <= time_i;
      if (alarm_we_i) alarm_q <= alarm_wdata_i;
    end
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign fld_chg[g] = time_i[FLD_LSB[g] +: FLD_W[g]] != prev_q[FLD_LSB[g] +: FLD_W[g]];
  end

  assign tod_hit  = time_i[TOD_W-1:0] == alarm_q[TOD_W-1:0];
  assign full_hit = tod_hit && (time_i[TIME_W-1:TOD_W] == alarm_q[TIME_W-1:TOD_W]);

  always_comb begin
    evt_o = '0;
    if (tick_i) begin
      evt_o[EV_SEC +: NFIELD] = fld_chg;
      evt_o[EV_ALARM]         = tod_hit;
      evt_o[EV_DAYALM]        = full_hit;
    end
  end

  assign alarm_o = alarm_q;

  // R4
  dayalm_implies_daily_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o[EV_DAYALM] |-> evt_o[EV_ALARM]);
  // R5
  no_evt_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |-> (evt_o == '0));
endmodule

// File: rtl/rtc_evt_stopwatch.sv
module rtc_evt_stopwatch #(
  parameter int SW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic [SW_W-1:0] load_val_i,
  output logic [SW_W-1:0] cnt_o,
  output logic            expire_o
);
  localparam logic [SW_W-1:0] ONE = SW_W'(1);
  logic [SW_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - ONE;
  end

  assign expire_o = tick_i && !load_i && (cnt_q == ONE);
  assign cnt_o    = cnt_q;

  // R9
  sw_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  // R9
  sw_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
  // R10
  sw_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/rtc_evt_status.sv
module rtc_evt_status #(
  parameter int EV_N  = 7,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_N-1:0]  set_i,
  input  logic [EV_N-1:0]  clr_i,
  input  logic             en_we_i,
  input  logic [EV_N-1:0]  en_wdata_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] enable_o,
  output logic             irq_o
);
  logic [EV_N-1:0] sts_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_i) | set_i;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign status_o = REG_W'(sts_q);
  assign enable_o = REG_W'(en_q);
  assign irq_o    = |(sts_q & en_q);

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((sts_q & $past(set_i)) == $past(set_i)));
  // R6
  sticky_unless_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0));
  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
endmodule

// File: rtl/rtc_evt_unit.sv
module rtc_evt_unit
  import rtc_evt_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int SW_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [TIME_W-1:0] wr_data_i,
  output logic [REG_W-1:0]  status_o,
  output logic [REG_W-1:0]  enable_o,
  output logic [TIME_W-1:0] alarm_o,
  output logic [SW_W-1:0]   swatch_o,
  output logic              irq_o
);
  wsel_e           sel;
  logic [EV_N-1:0] det_evt, set_vec, clr_vec;
  logic            sw_expire;

  assign sel = wsel_e'(wr_sel_i);

  rtc_evt_detect u_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .time_i        (time_i),
    .alarm_we_i    (wr_en_i && sel == SEL_ALARM),
    .alarm_wdata_i (wr_data_i),
    .alarm_o       (alarm_o),
    .evt_o         (det_evt)
  );

  rtc_evt_stopwatch #(.SW_W(SW_W)) u_swatch (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (wr_en_i && sel == SEL_SWATCH),
    .load_val_i (wr_data_i[SW_W-1:0]),
    .cnt_o      (swatch_o),
    .expire_o   (sw_expire)
  );

  always_comb begin
    set_vec            = det_evt;
    set_vec[EV_SWATCH] = sw_expire;
    clr_vec            = (wr_en_i && sel == SEL_STATUS) ? wr_data_i[EV_N-1:0] : '0;
  end

  rtc_evt_status #(.EV_N(EV_N), .REG_W(REG_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .en_we_i    (wr_en_i && sel == SEL_ENABLE),
    .en_wdata_i (wr_data_i[EV_N-1:0]),
    .status_o   (status_o),
    .enable_o   (enable_o),
    .irq_o      (irq_o)
  );

  // R1
  reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[REG_W-1:EV_N] == '0) && (enable_o[REG_W-1:EV_N] == '0));
  // R8
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (status_o != '0));
  // R9
  sw_expire_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_expire |=> status_o[EV_SWATCH]);
endmodule

// File: tb/rtc_evt_unit_tb.sv
`timescale 1ns/1ps
module rtc_evt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [31:0] time_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] status_o, enable_o, swatch_o;
  logic [31:0] alarm_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  logic [6:0]  m_sts = '0, m_en = '0;
  logic [31:0] m_alm = '0, m_prev = '0;
  logic [15:0] m_sw = '0;

  always #4 clk = ~clk;

  rtc_evt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .time_i(time_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .status_o(status_o), .enable_o(enable_o), .alarm_o(alarm_o),
    .swatch_o(swatch_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [6:0] events(input logic tk, input logic [31:0] tm, input logic [31:0] alm,
                                        input logic [31:0] prv);
    logic [6:0] e = '0;
    if (tk) begin
      e[2] = tm[5:0]   != prv[5:0];
      e[3] = tm[11:6]  != prv[11:6];
      e[4] = tm[16:12] != prv[16:12];
      e[5] = tm[31:17] != prv[31:17];
      e[1] = tm[16:0] == alm[16:0];
      e[6] = tm == alm;
    end
    return e;
  endfunction

  task automatic check_all(input string tag);
    chk({16'h0, status_o}, {25'h0, m_sts}, tag, "status");
    chk({16'h0, enable_o}, {25'h0, m_en}, tag, "enable");
    chk(alarm_o, m_alm, tag, "alarm");
    chk({16'h0, swatch_o}, {16'h0, m_sw}, tag, "swatch");
    chk({31'h0, irq_o}, {31'h0, |(m_sts & m_en)}, tag, "irq");
  endtask

  task automatic step(input logic tk, input logic [31:0] tm, input logic we, input logic [1:0] sel,
                      input logic [31:0] d, input string tag);
    logic [6:0]  ev;
    logic [6:0]  clr;
    logic [15:0] sw_n;
    tick_i = tk; time_i = tm; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    ev = events(tk, tm, m_alm, m_prev);
    sw_n = m_sw;
    if (we && sel == 2'd3) sw_n = d[15:0];
    else if (tk && m_sw != 0) begin
      sw_n = m_sw - 16'd1;
      if (m_sw == 16'd1) ev[0] = 1'b1;
    end
    clr = (we && sel == 2'd0) ? d[6:0] : 7'h0;
    @(posedge clk);
    m_sts = (m_sts & ~clr) | ev;
    if (we && sel == 2'd1) m_en = d[6:0];
    if (we && sel == 2'd2) m_alm = d;
    if (tk) m_prev = tm;
    m_sw = sw_n;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R7: enable upper bits dropped
    step(0, 0, 1, 2'd1, 32'hFFFF_FFFF, "R7");
    // R11: alarm readback
    step(0, 0, 1, 2'd2, {15'd3, 5'd10, 6'd20, 6'd30}, "R11");
    // R2: first tick vs zero previous, then single field changes
    step(1, {15'd0, 5'd0, 6'd0, 6'd1}, 0, 0, 0, "R2");
    step(0, 0, 1, 2'd0, 32'hFFFF, "R6");
    step(1, {15'd0, 5'd0, 6'd1, 6'd0}, 0, 0, 0, "R2");
    step(1, {15'd1, 5'd0, 6'd1, 6'd0}, 0, 0, 0, "R2");
    // R5: time changes with no tick
    step(0, 0, 1, 2'd0, 32'hFFFF, "R6");
    step(0, 32'hFFFF_FFFF, 0, 0, 0, "R5");
    // R3: daily match with different day
    step(1, {15'd9, 5'd10, 6'd20, 6'd30}, 0, 0, 0, "R3");
    // R4: full match
    step(1, {15'd3, 5'd10, 6'd20, 6'd30}, 0, 0, 0, "R4");
    // R6: partial clear, then set and clear same cycle
    step(0, 0, 1, 2'd0, 32'h0000_0002, "R6");
    step(1, {15'd3, 5'd10, 6'd20, 6'd30}, 1, 2'd0, 32'h0000_0042, "R6");
    step(0, 0, 1, 2'd0, 32'hFFFF, "R6");
    // R9: stopwatch count down, expire, hold; R8 irq
    step(0, 0, 1, 2'd1, 32'h1, "R8");
    step(0, 0, 1, 2'd3, 32'd2, "R9");
    step(1, {15'd3, 5'd10, 6'd20, 6'd30}, 0, 0, 0, "R9");
    step(1, {15'd3, 5'd10, 6'd20, 6'd30}, 0, 0, 0, "R9");
    step(1, {15'd3, 5'd10, 6'd20, 6'd30}, 0, 0, 0, "R9");
    step(0, 0, 1, 2'd0, 32'h1, "R8");
    step(0, 0, 1, 2'd3, 32'd0, "R9");
    // R10: load with tick when count is 1
    step(0, 0, 1, 2'd3, 32'd1, "R10");
    step(1, {15'd3, 5'd10, 6'd20, 6'd30}, 1, 2'd3, 32'd5, "R10");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] tm;
      logic        we;
      logic [1:0]  sel;
      logic [31:0] d;
      int          k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1: tm = m_alm;
        2, 3: tm = {15'($urandom_range(0, 3)), m_alm[16:0]};
        4:    tm = m_alm ^ 32'h1;
        5, 6: tm = m_prev + 32'd1;
        default: tm = $urandom;
      endcase
      we  = ($urandom_range(0, 4) == 0);
      sel = 2'($urandom_range(0, 3));
      d   = $urandom;
      if (sel == 2'd3) d = 32'($urandom_range(0, 4));
      if (sel == 2'd2) d = {15'($urandom_range(0, 3)), 17'($urandom)};
      step(1'($urandom_range(0, 1)), tm, we, sel, d, "R2 R3 R4 R6 R8 R9");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule